// File: doc/BRIEF.md
# Power-Fail Supervisor and Reset Timer

This controller sits between two digitized supply comparators and the parts of a battery-backed memory subsystem that must react to a failing supply. One comparator flag reports that the supply is above the write-protect level. The other reports that it is above the lower battery-switchover level. Both flags are asynchronous. Each passes through a two-flop synchronizer before any decision is made.

From the two flags the block produces four outputs:
- a write-protect signal that blocks memory writes;
- a battery-select signal that moves the memory onto its backup cell;
- a charge-enable signal;
- a low-drive enable for an open-drain host reset line.

Protection starts as soon as a fail is seen. Protection is released only after a recovery delay. The host reset is released after a second, longer delay. Both delays are parameters counted in clock cycles.

A one-time shipping seal keeps the backup cell disconnected until the supply first reaches the write-protect level. After that, backup stays armed for good. The seal returns to its factory state only through the block's own reset.

Top module: `pwr_supervisor`

## Requirements
- R1: After `rst_n` is released with both flags low, `wp_o` = 1, `rst_pull_o` = 1, `bat_sel_o` = 0 and `chg_en_o` = 0.
- R2: When `above_wp_i` falls, `wp_o` and `rst_pull_o` are both 1 by the second rising clock edge after the change. The synchronizer has two stages.
- R3: When `above_wp_i` rises and stays high, `wp_o` goes to 0 at rising edge number REC_CYCLES+2 counted from the change.
- R4: When `above_wp_i` rises and stays high, `rst_pull_o` goes to 0 at rising edge number RST_CYCLES+2 counted from the change. RST_CYCLES must exceed REC_CYCLES, so the reset is never released while protection is still on.
- R5: If `above_wp_i` drops while either delay is running, that delay starts again from zero once the flag returns.
- R6: Before `above_wp_i` has been seen high once after reset, `bat_sel_o` stays 0 even with `above_sw_i` low. Once the flag has been seen high, backup is armed and remains armed through later fails.
- R7: While armed, `bat_sel_o` equals the inverse of the synchronized `above_sw_i`. It follows either edge of the flag two clock edges later.
- R8: `chg_en_o` is 1 exactly when the synchronized `above_wp_i` is 1.
- R9: A new fail that arrives in the same cycle as the recovery delay expires keeps `wp_o` at 1 without a one-cycle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset; also restores the shipping seal |
| above_wp_i | input | 1 | Asynchronous flag: supply above write-protect level |
| above_sw_i | input | 1 | Asynchronous flag: supply above switchover level |
| wp_o | output | 1 | Memory write protection active |
| bat_sel_o | output | 1 | Memory powered from the backup cell |
| chg_en_o | output | 1 | Backup cell charging allowed |
| rst_pull_o | output | 1 | Enable for the low drive of the open-drain host reset |

## Verification
The case to watch is a supply dip that lands in the very cycle the recovery counter finishes. In that cycle the timer's release and the fail path's re-assertion meet on `wp_o`.

The bench provokes it as follows:
1. Raise the write-protect flag.
2. Drop the flag again at the falling edge that places the synchronized fall on the expiry edge.
3. Sample `wp_o` and the reset drive after every edge that follows.

A single low sample counts as a failure. A restarted, full-length release afterwards shows that the counter began again from zero.

// File: rtl/pwr_supervisor.sv
module pwr_supervisor #(
  parameter int REC_CYCLES = 20,
  parameter int RST_CYCLES = 56
) (
  input  logic clk,
  input  logic rst_n,
  input  logic above_wp_i,
  input  logic above_sw_i,
  output logic wp_o,
  output logic bat_sel_o,
  output logic chg_en_o,
  output logic rst_pull_o
);
  localparam int RW = $clog2(REC_CYCLES + 1);
  localparam int TW = $clog2(RST_CYCLES + 1);

  logic [1:0] wp_ff, sw_ff;
  logic       wp_ok, sw_ok;
  logic [RW-1:0] rec_cnt;
  logic [TW-1:0] rst_cnt;
  logic rec_done, rst_done, armed;

  initial begin
    AST_PARAM_ORDER: assert (RST_CYCLES > REC_CYCLES && REC_CYCLES > 0); // R4
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_ff <= '0;
      sw_ff <= '0;
    end else begin
      wp_ff <= {wp_ff[0], above_wp_i};
      sw_ff <= {sw_ff[0], above_sw_i};
    end
  end

  assign wp_ok = wp_ff[1];
  assign sw_ok = sw_ff[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_cnt  <= '0;
      rec_done <= 1'b0;
    end else if (!wp_ok) begin
      rec_cnt  <= '0;
      rec_done <= 1'b0;
    end else if (!rec_done) begin
      if (rec_cnt == RW'(REC_CYCLES - 1)) rec_done <= 1'b1;
      else rec_cnt <= rec_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_cnt  <= '0;
      rst_done <= 1'b0;
    end else if (!wp_ok) begin
      rst_cnt  <= '0;
      rst_done <= 1'b0;
    end else if (!rst_done) begin
      if (rst_cnt == TW'(RST_CYCLES - 1)) rst_done <= 1'b1;
      else rst_cnt <= rst_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else if (wp_ok) armed <= 1'b1;
  end

  assign wp_o       = ~(wp_ok & rec_done);
  assign rst_pull_o = ~(wp_ok & rst_done);
  assign bat_sel_o  = armed & ~sw_ok;
  assign chg_en_o   = wp_ok;

  AST_REC_BOUND: assert property (@(posedge clk) disable iff (!rst_n) rec_cnt < RW'(REC_CYCLES)); // R3
  AST_RST_BOUND: assert property (@(posedge clk) disable iff (!rst_n) rst_cnt < TW'(RST_CYCLES)); // R4
  AST_WP_RELEASE_GOOD: assert property (@(posedge clk) disable iff (!rst_n) $fell(wp_o) |-> $past(wp_ok)); // R3
  AST_RST_AFTER_WP: assert property (@(posedge clk) disable iff (!rst_n) !rst_pull_o |-> !wp_o); // R4
  AST_FAIL_BOTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(wp_ok) |-> (wp_o && rst_pull_o)); // R2
  AST_SEAL_ONEWAY: assert property (@(posedge clk) disable iff (!rst_n) armed |=> armed); // R6
  AST_NO_CHG_ON_BAT: assert property (@(posedge clk) disable iff (!rst_n) bat_sel_o |-> !chg_en_o); // R8
  AST_REC_RESTART: assert property (@(posedge clk) disable iff (!rst_n) !wp_ok |=> (rec_cnt == '0 && rst_cnt == '0)); // R5
endmodule

// File: tb/pwr_supervisor_test.sv
module pwr_supervisor_test;
  localparam int CLK_PERIOD = 10;
  localparam int REC = 20;
  localparam int RST = 56;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic above_wp_i = 1'b0;
  logic above_sw_i = 1'b0;
  logic wp_o, bat_sel_o, chg_en_o, rst_pull_o;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_supervisor #(.REC_CYCLES(REC), .RST_CYCLES(RST)) uut (
    .clk(clk), .rst_n(rst_n), .above_wp_i(above_wp_i), .above_sw_i(above_sw_i),
    .wp_o(wp_o), .bat_sel_o(bat_sel_o), .chg_en_o(chg_en_o), .rst_pull_o(rst_pull_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges(input int k);
    for (int i = 0; i < k; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  // Raises the write-protect flag and reports the edge counts at which the
  // protect and reset outputs fall.
  task automatic measure_release(output int nw, output int nr);
    nw = 0;
    nr = 0;
    @(negedge clk);
    above_wp_i = 1'b1;
    above_sw_i = 1'b1;
    for (int i = 1; i <= RST + 10; i++) begin
      @(posedge clk);
      #1;
      if (nw == 0 && !wp_o) nw = i;
      if (nr == 0 && !rst_pull_o) nr = i;
    end
  endtask

  task automatic t_reset;
    edges(3);
    chk("R1 wp", wp_o, 1);
    chk("R1 rst", rst_pull_o, 1);
    chk("R1 bat", bat_sel_o, 0);
    chk("R1 chg", chg_en_o, 0);
  endtask

  task automatic t_seal;
    edges(5);
    chk("R6 sealed bat_sel", bat_sel_o, 0);
  endtask

  task automatic t_powerup;
    int nw, nr;
    measure_release(nw, nr);
    chk("R3 wp release edge", nw, REC + 2);
    chk("R4 rst release edge", nr, RST + 2);
    chk("R8 chg on", chg_en_o, 1);
  endtask

  task automatic t_fail;
    @(negedge clk);
    above_wp_i = 1'b0;
    edges(1);
    chk("R2 wp before sync", wp_o, 0);
    edges(1);
    chk("R2 wp asserted", wp_o, 1);
    chk("R2 rst asserted", rst_pull_o, 1);
    chk("R8 chg off", chg_en_o, 0);
    chk("R6 armed, bat still off", bat_sel_o, 0);
  endtask

  task automatic t_switch;
    @(negedge clk);
    above_sw_i = 1'b0;
    edges(1);
    chk("R7 bat one edge", bat_sel_o, 0);
    edges(1);
    chk("R7 bat on", bat_sel_o, 1);
    edges(20);
    chk("R6 stays armed", bat_sel_o, 1);
    @(negedge clk);
    above_sw_i = 1'b1;
    edges(2);
    chk("R7 bat off", bat_sel_o, 0);
  endtask

  task automatic t_dip;
    int nw, nr;
    @(negedge clk);
    above_wp_i = 1'b1;
    edges(REC);
    @(negedge clk);
    above_wp_i = 1'b0;
    edges(4);
    chk("R5 dip protect", wp_o, 1);
    measure_release(nw, nr);
    chk("R5 rec restart", nw, REC + 2);
    chk("R5 rst restart", nr, RST + 2);
  endtask

  task automatic t_collide;
    int gaps = 0, nw, nr;
    @(negedge clk);
    above_wp_i = 1'b0;
    edges(4);
    @(negedge clk);
    above_wp_i = 1'b1;
    edges(REC);
    @(negedge clk);
    above_wp_i = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk);
      #1;
      if (!wp_o || !rst_pull_o) gaps++;
    end
    chk("R9 no protect gap", gaps, 0);
    measure_release(nw, nr);
    chk("R9 full restart", nw, REC + 2);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3 + 2);
    rst_n = 1'b1;
    t_reset();
    t_seal();
    t_powerup();
    t_fail();
    t_switch();
    t_dip();
    t_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule